// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns the run-length record of one received infrared packet into a 32-bit pulse-distance code. Each input byte describes one run of the demodulated signal: its level (mark or space) and how many sample ticks it lasted. One tick is about 42.7 us. Consecutive bytes of the same level add together into a single run, so a long run may arrive split over several bytes. The decoder first looks for a long leader mark and then a leader space. It then reads 32 data bits. Each bit is a short mark followed by a space whose length gives the bit value.

An upstream stage supplies the bytes through a valid/ready stream and raises a one-cycle packet-end strobe once the line has gone idle. On that strobe the decoder reports the frame. A decode error gives an all-ones code with the error flag set. A complete frame gives the 32 collected bits, with a flag saying whether the command byte matches its inverted copy. After every packet end the decoder returns to the leader search for the next packet.

The controller has six states. LEAD_MARK adds up mark runs until a space arrives. It moves to LEAD_SPACE if the sum is long enough, and otherwise clears the sum and stays. LEAD_SPACE adds up space runs until a mark arrives. It moves to BIT_MARK if the sum is long enough, and otherwise clears the sum and stays. BIT_MARK adds up the data mark; a space moves it to BIT_SPACE, or to ERROR if the mark was too long. BIT_SPACE adds up the data space; a mark classifies the bit and returns to BIT_MARK. After the last bit it goes to DONE, and if the space was too long it goes to ERROR. DONE and ERROR ignore further bytes. Packet end leads from any state back to LEAD_MARK.

Top module: `nec_frame_decoder`

## Requirements
- R1: After reset, out_valid, out_err and out_ok are 0 and in_ready is 1; in_ready stays 1 while reset is low, and every byte with in_valid high is consumed.
- R2: A byte has its level in bit 7 (1 = mark, 0 = space) and its duration in ticks in bits 6:0. Consecutive bytes of the same level are summed into one run, so how a run is split into bytes does not change the result.
- R3: At the start of each packet the leader-mark sum begins at ACTIVE_DELAY/2 (64 ticks by default). When a space arrives, the leader is accepted only if the sum exceeds 80. Otherwise the sum is cleared to 0 and the search goes on.
- R4: The leader space, meaning the sum of spaces up to the next mark, must exceed 40 ticks. This accepts both the normal (~105 tick) and the repeat (~53 tick) leader. A shorter space clears the sum and the search continues; a packet that ends there is an error.
- R5: A data-bit mark longer than 26 ticks makes the frame an error.
- R6: A data-bit space longer than 53 ticks makes the frame an error. A space of 27 to 53 ticks decodes as 1, and a space of 26 or fewer decodes as 0.
- R7: Bits fill the code from bit 0 upward. A bit's space is closed by the mark that follows it. After the 32nd bit, further bytes in the packet are ignored.
- R8: A frame with a decode error, or one that ends before 32 bits are collected, is reported with out_code = 0xFFFFFFFF, out_err = 1 and out_ok = 0.
- R9: For a complete frame, out_ok is 1 exactly when out_code[31:24] XOR out_code[23:16] equals 0xFF. The address bits 15:0 have no effect on out_ok.
- R10: out_valid is a one-cycle strobe in the cycle after pkt_end, and it is never raised otherwise. A byte accepted in the same cycle as pkt_end belongs to the packet that is ending. The next packet starts a fresh leader search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Run byte present |
| in_ready | output | 1 | Decoder accepts run bytes |
| in_byte | input | 8 | Run byte: bit 7 level, bits 6:0 ticks |
| pkt_end | input | 1 | One-cycle end-of-packet strobe |
| out_valid | output | 1 | Result strobe |
| out_code | output | 32 | Decoded code, or all ones on error |
| out_err | output | 1 | Decode error or truncated frame |
| out_ok | output | 1 | Command byte matches its inverse |

## Verification
All decoding happens as bytes arrive, so the only result is the registered frame report. It appears one clock edge after the edge that samples pkt_end. The bench drives every input on the falling edge and presents pkt_end one falling edge after the last byte. It then compares out_code, out_err and out_ok at the next falling edge, which is the first one after the reporting edge. At the falling edge after that it checks that out_valid has dropped again. Frames are built by bench functions from a chosen code and chosen run lengths, with random byte splits. The expected result follows directly from those lengths and the thresholds.

// File: rtl/nec_pkg.sv
package nec_pkg;

    localparam int RUN_TICK_W = 7;

    typedef struct packed {
        logic                  mark;
        logic [RUN_TICK_W-1:0] ticks;
    } run_byte_t;

    typedef enum logic [2:0] {
        S_LEAD_MARK  = 3'd0,
        S_LEAD_SPACE = 3'd1,
        S_BIT_MARK   = 3'd2,
        S_BIT_SPACE  = 3'd3,
        S_DONE       = 3'd4,
        S_ERROR      = 3'd5
    } dec_state_t;

endpackage

// File: rtl/nec_thresh.sv
// Threshold comparators applied to the accumulated run length.
module nec_thresh #(
    parameter int LEN_W          = 12,
    parameter int LEAD_MARK_MIN  = 80,
    parameter int LEAD_SPACE_MIN = 40,
    parameter int MARK_MAX       = 26,
    parameter int SPACE_MID      = 26,
    parameter int SPACE_MAX      = 53
) (
    input  logic [LEN_W-1:0] len,
    output logic             lead_mark_ok,
    output logic             lead_space_ok,
    output logic             mark_too_long,
    output logic             space_is_one,
    output logic             space_too_long
);
    assign lead_mark_ok   = len > LEN_W'(LEAD_MARK_MIN);
    assign lead_space_ok  = len > LEN_W'(LEAD_SPACE_MIN);
    assign mark_too_long  = len > LEN_W'(MARK_MAX);
    assign space_is_one   = len > LEN_W'(SPACE_MID);
    assign space_too_long = len > LEN_W'(SPACE_MAX);
endmodule

// File: rtl/nec_cmd_check.sv
// Command byte against its inverted copy; address bytes not inspected.
module nec_cmd_check #(
    parameter int CODE_W = 32
) (
    input  logic [CODE_W-1:0] code,
    output logic              match
);
    assign match = ((code[CODE_W-1 -: 8] ^ code[CODE_W-9 -: 8]) == 8'hFF);
endmodule

// File: rtl/nec_frame_decoder.sv
module nec_frame_decoder
    import nec_pkg::*;
#(
    parameter int CODE_W         = 32,
    parameter int LEN_W          = 12,
    parameter int ACTIVE_DELAY   = 128,
    parameter int LEAD_MARK_MIN  = 80,
    parameter int LEAD_SPACE_MIN = 40,
    parameter int MARK_MAX       = 26,
    parameter int SPACE_MID      = 26,
    parameter int SPACE_MAX      = 53
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    input  logic              pkt_end,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic              out_err,
    output logic              out_ok
);
    localparam int CNT_W = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);
    localparam logic [LEN_W-1:0] LEN_INIT = LEN_W'(ACTIVE_DELAY / 2);

    dec_state_t        st, st_n;
    logic [LEN_W-1:0]  len, len_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [CODE_W-1:0] code, code_n;
    logic              rdy;

    run_byte_t         rb;
    logic              take;
    logic [LEN_W:0]    sum_ext;
    logic [LEN_W-1:0]  sum, dur;
    logic              lead_mark_ok, lead_space_ok;
    logic              mark_too_long, space_is_one, space_too_long;
    logic              cmd_match;

    assign in_ready = rdy;
    assign rb       = run_byte_t'(in_byte);
    assign take     = in_valid && rdy;
    assign dur      = LEN_W'(rb.ticks);
    assign sum_ext  = {1'b0, len} + {1'b0, dur};
    assign sum      = sum_ext[LEN_W] ? '1 : sum_ext[LEN_W-1:0];

    nec_thresh #(
        .LEN_W(LEN_W), .LEAD_MARK_MIN(LEAD_MARK_MIN),
        .LEAD_SPACE_MIN(LEAD_SPACE_MIN), .MARK_MAX(MARK_MAX),
        .SPACE_MID(SPACE_MID), .SPACE_MAX(SPACE_MAX)
    ) u_thr (
        .len(len),
        .lead_mark_ok(lead_mark_ok),
        .lead_space_ok(lead_space_ok),
        .mark_too_long(mark_too_long),
        .space_is_one(space_is_one),
        .space_too_long(space_too_long)
    );

    nec_cmd_check #(.CODE_W(CODE_W)) u_chk_cmd (
        .code(code_n),
        .match(cmd_match)
    );

    // Next-state and datapath update for one accepted run byte.
    always_comb begin
        st_n   = st;
        len_n  = len;
        cnt_n  = cnt;
        code_n = code;
        if (take) begin
            unique case (st)
                S_LEAD_MARK: begin
                    if (rb.mark) begin
                        len_n = sum;
                    end else if (lead_mark_ok) begin
                        st_n  = S_LEAD_SPACE;
                        len_n = dur;
                    end else begin
                        len_n = '0;
                    end
                end
                S_LEAD_SPACE: begin
                    if (!rb.mark) begin
                        len_n = sum;
                    end else if (lead_space_ok) begin
                        st_n  = S_BIT_MARK;
                        len_n = dur;
                    end else begin
                        len_n = '0;
                    end
                end
                S_BIT_MARK: begin
                    if (rb.mark) begin
                        len_n = sum;
                    end else if (mark_too_long) begin
                        st_n = S_ERROR;
                    end else begin
                        st_n  = S_BIT_SPACE;
                        len_n = dur;
                    end
                end
                S_BIT_SPACE: begin
                    if (!rb.mark) begin
                        len_n = sum;
                    end else if (space_too_long) begin
                        st_n = S_ERROR;
                    end else begin
                        code_n[cnt] = space_is_one;
                        cnt_n       = cnt + 1'b1;
                        len_n       = dur;
                        st_n        = (cnt == LAST_BIT) ? S_DONE : S_BIT_MARK;
                    end
                end
                S_DONE, S_ERROR: begin
                end
                default: st_n = S_ERROR;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst || pkt_end) begin
            st   <= S_LEAD_MARK;
            len  <= LEN_INIT;
            cnt  <= '0;
            code <= '0;
        end else begin
            st   <= st_n;
            len  <= len_n;
            cnt  <= cnt_n;
            code <= code_n;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy       <= 1'b0;
            out_valid <= 1'b0;
            out_code  <= '0;
            out_err   <= 1'b0;
            out_ok    <= 1'b0;
        end else begin
            rdy       <= 1'b1;
            out_valid <= pkt_end;
            if (pkt_end) begin
                out_err  <= (st_n != S_DONE);
                out_code <= (st_n == S_DONE) ? code_n : '1;
                out_ok   <= (st_n == S_DONE) && cmd_match;
            end
        end
    end
endmodule

// File: rtl/nec_frame_decoder_chk.sv
module nec_frame_decoder_chk #(
    parameter int CODE_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pkt_end,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_code,
    input logic              out_err,
    input logic              out_ok
);
    p_strobe_src_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pkt_end));

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !pkt_end |=> !out_valid);

    p_err_code_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_code == '1));

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_ok && out_err));

    p_ok_match_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ok) |->
            ((out_code[CODE_W-1 -: 8] ^ out_code[CODE_W-9 -: 8]) == 8'hFF));

    p_match_ok_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err &&
         ((out_code[CODE_W-1 -: 8] ^ out_code[CODE_W-9 -: 8]) == 8'hFF)) |-> out_ok);
endmodule

bind nec_frame_decoder nec_frame_decoder_chk #(.CODE_W(CODE_W)) u_prop (
    .clk(clk), .rst(rst), .pkt_end(pkt_end), .out_valid(out_valid),
    .out_code(out_code), .out_err(out_err), .out_ok(out_ok)
);

// File: tb/nec_frame_decoder_test.sv
module nec_frame_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        pkt_end = 1'b0;
    logic        out_valid;
    logic [31:0] out_code;
    logic        out_err;
    logic        out_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] q[$];

    always #10 clk = ~clk;

    nec_frame_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .pkt_end(pkt_end), .out_valid(out_valid),
        .out_code(out_code), .out_err(out_err), .out_ok(out_ok)
    );

    function automatic bit cmd_ok(input logic [31:0] c);
        return (c[31:24] ^ c[23:16]) == 8'hFF;
    endfunction

    // R2: split one run into bytes of at most maxc ticks
    task automatic push_run(input bit lvl, input int ticks, input int maxc);
        int left = ticks;
        while (left > 0) begin
            int c = 1 + int'($urandom % maxc);
            if (c > left) c = left;
            if (c > 127) c = 127;
            q.push_back({lvl, 7'(c)});
            left -= c;
        end
    endtask

    task automatic make_frame(input logic [31:0] code, input int lm, input int ls,
                              input int mk, input int s0, input int s1,
                              input int bad_idx, input int bad_mk, input int bad_sp,
                              input bit trail, input int maxc);
        push_run(1'b1, lm, maxc);
        push_run(1'b0, ls, maxc);
        for (int i = 0; i < 32; i++) begin
            int m = mk;
            int s = code[i] ? s1 : s0;
            if (i == bad_idx) begin
                if (bad_mk > 0) m = bad_mk;
                if (bad_sp > 0) s = bad_sp;
            end
            push_run(1'b1, m, maxc);
            push_run(1'b0, s, maxc);
        end
        if (trail) push_run(1'b1, mk, maxc);
    endtask

    task automatic run_packet(input string tag, input logic [31:0] exp_code,
                              input bit exp_err, input bit exp_ok);
        foreach (q[i]) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = q[i];
        end
        q.delete();
        @(negedge clk);
        in_valid = 1'b0;
        pkt_end  = 1'b1;
        @(negedge clk);
        pkt_end  = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_code !== exp_code ||
            out_err !== exp_err || out_ok !== exp_ok) begin
            errors++;
            $display("FAIL %s: valid=%b code=%h err=%b ok=%b expected valid=1 code=%h err=%b ok=%b",
                     tag, out_valid, out_code, out_err, out_ok, exp_code, exp_err, exp_ok);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 strobe width (%s): out_valid=%b expected 0", tag, out_valid);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        void'($urandom(32'd20161027));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_ok !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: valid=%b err=%b ok=%b ready=%b expected 0 0 0 1",
                     out_valid, out_err, out_ok, in_ready);
        end

        // R6 R7: nominal frame, LSB first
        c = 32'hEF10_A55A;
        make_frame(c, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R6 R7 nominal", c, 1'b0, 1'b1);

        // R2: single-tick bytes give the same result
        make_frame(c, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 1);
        run_packet("R2 one-tick split", c, 1'b0, 1'b1);

        // R4: repeat leader 53, boundary 41 accepted, 40 rejected
        make_frame(c, 210, 53, 13, 13, 39, -1, 0, 0, 1'b1, 20);
        run_packet("R4 repeat leader", c, 1'b0, 1'b1);
        make_frame(c, 210, 41, 13, 13, 39, -1, 0, 0, 1'b1, 20);
        run_packet("R4 space 41", c, 1'b0, 1'b1);
        make_frame(c, 210, 40, 13, 13, 39, -1, 0, 0, 1'b1, 20);
        run_packet("R4 space 40", 32'hFFFF_FFFF, 1'b1, 1'b0);

        // R3: initial sum 64: mark 17 accepted, 16 rejected
        make_frame(c, 17, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R3 init 17", c, 1'b0, 1'b1);
        make_frame(c, 16, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R3 init 16", 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R3: after a failed leader the sum restarts at 0
        push_run(1'b1, 10, 127); push_run(1'b0, 5, 127);
        make_frame(c, 81, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R3 cleared 81", c, 1'b0, 1'b1);
        push_run(1'b1, 10, 127); push_run(1'b0, 5, 127);
        make_frame(c, 80, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R3 cleared 80", 32'hFFFF_FFFF, 1'b1, 1'b0);

        // R5 R6: limits 26/26/53 accepted
        make_frame(c, 210, 105, 26, 26, 53, -1, 0, 0, 1'b1, 9);
        run_packet("R5 R6 limits", c, 1'b0, 1'b1);
        make_frame(c, 210, 105, 13, 26, 27, -1, 0, 0, 1'b1, 9);
        run_packet("R6 mid 26/27", c, 1'b0, 1'b1);
        // R5: mark 27
        make_frame(c, 210, 105, 13, 13, 39, 31, 27, 0, 1'b1, 9);
        run_packet("R5 mark 27", 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R6: space 54
        make_frame(c, 210, 105, 13, 13, 39, 5, 0, 54, 1'b1, 9);
        run_packet("R6 space 54", 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R8: truncated (no closing mark)
        make_frame(c, 210, 105, 13, 13, 39, -1, 0, 0, 1'b0, 127);
        run_packet("R8 truncated", 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R10: fresh search after error
        make_frame(c, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R10 restart", c, 1'b0, 1'b1);

        // R7: trailing junk after 32 bits ignored
        make_frame(c, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        push_run(1'b0, 120, 127); push_run(1'b1, 120, 127); push_run(1'b0, 3, 127);
        run_packet("R7 trailing ignored", c, 1'b0, 1'b1);

        // R9: mismatch, and address has no effect
        make_frame(32'hEE10_0000, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R9 mismatch", 32'hEE10_0000, 1'b0, 1'b0);
        make_frame(32'h00FF_FFFF, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R9 address ones", 32'h00FF_FFFF, 1'b0, 1'b1);
        make_frame(32'h00FF_0000, 210, 105, 13, 13, 39, -1, 0, 0, 1'b1, 127);
        run_packet("R9 address zeros", 32'h00FF_0000, 1'b0, 1'b1);

        // Random frames: R2 R6 R7 R9
        for (int n = 0; n < 40; n++) begin
            logic [7:0]  cmd;
            logic [7:0]  inv;
            logic [15:0] adr;
            int ls;
            cmd = 8'($urandom);
            adr = 16'($urandom);
            inv = ($urandom % 4 == 0) ? 8'($urandom) : ~cmd;
            c   = {inv, cmd, adr};
            ls  = ($urandom % 2 == 0) ? 41 + int'($urandom % 80) : 53;
            make_frame(c, 180 + int'($urandom % 51), ls,
                       8 + int'($urandom % 19), 8 + int'($urandom % 19),
                       27 + int'($urandom % 27), -1, 0, 0, 1'b1,
                       1 + int'($urandom % 60));
            run_packet("R2 R6 R7 R9 random", c, 1'b0, cmd_ok(c));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule